// File: doc/BRIEF.md
# Revolution Period Meter

This block times one full turn of a motor whose speed encoder gives one pulse per revolution. A start strobe arms it. It then samples the encoder level and waits for the edge that begins a clean interval. A high level means it waits for a falling edge, and a low level means it waits for a rising edge. It counts the two half-cycles on their own timers, with the timer restarted at the middle edge. It adds the two counts to form the period. A restoring divider then turns a clock-frequency constant into revolutions per second, producing one quotient bit per cycle.

If an expected edge does not come in time, the block stops and raises a stall flag. The same happens if a counter reaches its ceiling. The flag holds until an operator gives a continue strobe. The block then samples the level again and retries.

Top module: `rev_period_meter`

## Requirements
- R1: While reset is held and right after it, `hi_time`, `lo_time`, `period` and `rate` are zero, and `done` and `stall` are low.
- R2: If the synchronised encoder is high when start is accepted, the block waits for a falling edge. It times the low half first and then the high half.
- R3: If the synchronised encoder is low when start is accepted, the block waits for a rising edge. It times the high half first and then the low half.
- R4: Each half-time equals the number of clock cycles between the two encoder transitions that bound it, when the encoder changes once per clock period at most. An interval of one cycle reads 1.
- R5: `period` equals `hi_time + lo_time` and is one bit wider than either.
- R6: When a revolution has been timed, `rate` becomes floor(CLK_HZ / period), and `done` pulses high for exactly one cycle.
- R7: If `timeout_lim` is nonzero and no expected edge arrives within `timeout_lim` cycles, `stall` rises and stays high until `cont`. An interval of exactly `timeout_lim` cycles does not stall. A `timeout_lim` of 0 disables this check.
- R8: On `cont` in the stalled state, `stall` falls and the block re-samples the level and measures normally, ending with `done`.
- R9: When an interval reaches 2^CW-1 cycles without its closing edge, that half-time saturates at all ones and `stall` rises.
- R10: After `done`, all results hold until the next start. An accepted start clears them to zero on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a measurement (accepted when idle) |
| enc_in | input | 1 | Raw encoder level, asynchronous |
| cont | input | 1 | Operator continue after a stall |
| timeout_lim | input | CW | Edge timeout in cycles, 0 disables |
| hi_time | output | CW | High half-time in cycles |
| lo_time | output | CW | Low half-time in cycles |
| period | output | CW+1 | Revolution period in cycles |
| rate | output | DW | Revolutions per second |
| done | output | 1 | One-cycle pulse when results are valid |
| stall | output | 1 | Motor-not-moving / overflow fault |

## Verification
The bench starts measurements at both encoder levels and checks that the half-times are not swapped. A design that ignored the start level would report the low time as the high time. It uses one-cycle half-periods to catch an off-by-one in the counter restart. It tests an interval exactly at the timeout limit and one past it, so that a comparison one cycle early or late would stall a good motor or let a stalled one pass. It checks that the stall holds without `cont` and that the retry afterwards gives correct numbers. It also checks that an overlong interval saturates instead of wrapping to a small value.

// File: rtl/rev_period_meter.sv
module rev_period_meter #(
  parameter int unsigned CW = 24,
  parameter int unsigned DW = 32,
  parameter logic [DW-1:0] CLK_HZ = 32'd50_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          enc_in,
  input  logic          cont,
  input  logic [CW-1:0] timeout_lim,
  output logic [CW-1:0] hi_time,
  output logic [CW-1:0] lo_time,
  output logic [CW:0]   period,
  output logic [DW-1:0] rate,
  output logic          done,
  output logic          stall
);
  localparam logic [CW-1:0] MAXC = '1;
  localparam int unsigned BW = $clog2(DW + 1);

  typedef enum logic [2:0] {IDLE, ARM, FIRST, SECOND, DIV, FAULT} st_t;
  st_t st;

  logic s1, s2, s3;
  logic hi_first, wait_rise;
  logic [CW-1:0] cnt;
  logic [CW+1:0] rem;
  logic [DW-1:0] dq;
  logic [BW-1:0] bcnt;

  wire rise = s2 & ~s3;
  wire fall = ~s2 & s3;
  wire edge_hit = wait_rise ? rise : fall;
  wire [CW-1:0] cnt_nx = cnt + 1'b1;
  wire sat = (cnt_nx == MAXC);
  wire limit_hit = sat || ((timeout_lim != '0) && (cnt_nx == timeout_lim));
  wire [CW+1:0] trial = {rem[CW:0], dq[DW-1]};
  wire fits = trial >= {1'b0, period};

  assign period = {1'b0, hi_time} + {1'b0, lo_time};

  always_ff @(posedge clk) begin
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {enc_in, s1, s2};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      hi_time <= '0; lo_time <= '0; rate <= '0;
      done <= 1'b0; stall <= 1'b0;
      cnt <= '0; hi_first <= 1'b0; wait_rise <= 1'b0;
      rem <= '0; dq <= '0; bcnt <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          hi_time <= '0; lo_time <= '0; rate <= '0; stall <= 1'b0;
          cnt <= '0; hi_first <= ~s2; wait_rise <= ~s2;
          st <= ARM;
        end
        ARM, FIRST, SECOND: begin
          if (edge_hit) begin
            cnt <= '0;
            wait_rise <= ~wait_rise;
            if (st == FIRST) begin
              if (hi_first) hi_time <= cnt_nx; else lo_time <= cnt_nx;
            end
            if (st == SECOND) begin
              if (hi_first) lo_time <= cnt_nx; else hi_time <= cnt_nx;
            end
            case (st)
              ARM:     st <= FIRST;
              FIRST:   st <= SECOND;
              default: begin
                st <= DIV; rem <= '0; dq <= CLK_HZ; bcnt <= '0;
              end
            endcase
          end else if (limit_hit) begin
            stall <= 1'b1;
            st <= FAULT;
            if (sat && st == FIRST) begin
              if (hi_first) hi_time <= MAXC; else lo_time <= MAXC;
            end
            if (sat && st == SECOND) begin
              if (hi_first) lo_time <= MAXC; else hi_time <= MAXC;
            end
          end else begin
            cnt <= cnt_nx;
          end
        end
        DIV: begin
          rem  <= fits ? trial - {1'b0, period} : trial;
          dq   <= {dq[DW-2:0], fits};
          bcnt <= bcnt + 1'b1;
          if (bcnt == BW'(DW - 1)) begin
            rate <= {dq[DW-2:0], fits};
            done <= 1'b1;
            st <= IDLE;
          end
        end
        FAULT: if (cont) begin
          stall <= 1'b0;
          hi_time <= '0; lo_time <= '0;
          cnt <= '0; hi_first <= ~s2; wait_rise <= ~s2;
          st <= ARM;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module rev_period_meter_chk #(
  parameter int unsigned CW = 24,
  parameter int unsigned DW = 32,
  parameter logic [DW-1:0] CLK_HZ = 32'd50_000_000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cont,
  input logic [CW-1:0] hi_time,
  input logic [CW-1:0] lo_time,
  input logic [CW:0]   period,
  input logic [DW-1:0] rate,
  input logic          done,
  input logic          stall
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  rate_quotient_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((64'(rate) * 64'(period) <= 64'(CLK_HZ)) &&
              ((64'(rate) + 64'd1) * 64'(period) > 64'(CLK_HZ))));
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !cont) |=> stall);
  // R7
  stall_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n) stall |-> !done);
  // R4
  halves_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hi_time != '0 && lo_time != '0));
  // R10
  hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) && !stall && !done |-> $stable(rate));
endmodule

bind rev_period_meter rev_period_meter_chk #(.CW(CW), .DW(DW), .CLK_HZ(CLK_HZ)) chk (
  .clk(clk), .rst_n(rst_n), .cont(cont), .hi_time(hi_time), .lo_time(lo_time),
  .period(period), .rate(rate), .done(done), .stall(stall));

// File: tb/rev_period_meter_test.sv
module rev_period_meter_test;
  localparam int CLK_NS = 10;
  localparam int CW = 10;
  localparam int DW = 32;
  localparam logic [DW-1:0] HZ = 32'd100000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, enc = 1'b0, cont = 1'b0;
  logic [CW-1:0] lim = '0;
  logic [CW-1:0] hi_time, lo_time;
  logic [CW:0] period;
  logic [DW-1:0] rate;
  logic done, stall;

  rev_period_meter #(.CW(CW), .DW(DW), .CLK_HZ(HZ)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .enc_in(enc), .cont(cont),
    .timeout_lim(lim), .hi_time(hi_time), .lo_time(lo_time), .period(period),
    .rate(rate), .done(done), .stall(stall));

  always #(CLK_NS/2) clk = ~clk;

  typedef struct { int hi; int lo; } exp_t;
  exp_t q[$];
  exp_t e;
  int nvec = 0, nbad = 0;

  task automatic check(string tag, longint act, longint exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) check("R6 unexpected done", 1, 0);
      else begin
        e = q.pop_front();
        check("R2/R3/R4 hi_time", hi_time, e.hi);
        check("R2/R3/R4 lo_time", lo_time, e.lo);
        check("R5 period", period, e.hi + e.lo);
        check("R6 rate", rate, HZ / (e.hi + e.lo));
      end
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic lvl(bit v, int n); enc = v; cyc(n); endtask
  task automatic pulse_start; start = 1'b1; cyc(1); start = 1'b0; endtask
  task automatic pulse_cont; cont = 1'b1; cyc(1); cont = 1'b0; endtask

  task automatic wait_done(string tag);
    int k = 0;
    while (!done && k < 5000) begin cyc(1); k++; end
    if (k == 5000) check({tag, " done never seen"}, 0, 1);
    cyc(1);
    check({tag, " done one cycle"}, done, 0);
  endtask

  task automatic meas_high_first(int lo, int hi);
    q.push_back('{hi: hi, lo: lo});
    lvl(1, 4); pulse_start; lvl(1, 4);
    lvl(0, lo); lvl(1, hi); lvl(0, 3);
    wait_done("R2");
  endtask

  task automatic meas_low_first(int hi, int lo);
    q.push_back('{hi: hi, lo: lo});
    lvl(0, 4); pulse_start; lvl(0, 4);
    lvl(1, hi); lvl(0, lo); lvl(1, 3);
    wait_done("R3");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    cyc(3);
    check("R1 hi_time", hi_time, 0);
    check("R1 lo_time", lo_time, 0);
    check("R1 rate", rate, 0);
    check("R1 done", done, 0);
    check("R1 stall", stall, 0);
    rst_n = 1'b1;
    cyc(2);
    check("R1 period", period, 0);
    lim = 10'd200;

    meas_high_first(40, 25);
    meas_low_first(7, 13);
    meas_low_first(1, 1);
    meas_high_first(3, 90);

    // R7 boundary: intervals equal to the limit do not stall
    lim = 10'd50;
    meas_low_first(50, 50);
    check("R7 no stall at limit", stall, 0);

    // R10 hold
    cyc(20);
    check("R10 hi hold", hi_time, 50);
    check("R10 rate hold", rate, HZ / 100);

    // R10 clear on start; then R7 timeout on the low half
    lim = 10'd30;
    pulse_start;
    check("R10 rate cleared", rate, 0);
    check("R10 hi cleared", hi_time, 0);
    lvl(1, 4); lvl(0, 60);
    check("R7 stall raised", stall, 1);
    check("R7 no done", done, 0);
    lvl(0, 20);
    check("R7 stall held", stall, 1);
    lim = 10'd200;
    pulse_cont;
    check("R8 stall cleared", stall, 0);
    q.push_back('{hi: 22, lo: 17});
    lvl(0, 4); lvl(1, 22); lvl(0, 17); lvl(1, 3);
    wait_done("R8");

    // R9 saturation with timeout disabled
    lim = '0;
    lvl(0, 4); pulse_start; lvl(0, 4); lvl(1, 1100);
    check("R9 stall", stall, 1);
    check("R9 hi saturated", hi_time, 1023);
    check("R9 lo untouched", lo_time, 0);
    pulse_cont;
    q.push_back('{hi: 9, lo: 11});
    lvl(1, 3); lvl(0, 11); lvl(1, 9); lvl(0, 3);
    wait_done("R8 retry");

    check("R6 queue drained", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule